// File: doc/BRIEF.md
# Multi-Lane PRBS Loopback Checker

This block checks a set of byte-wide receive lanes that carry a looped-back pseudo-random stream. An upstream aligner has already found byte boundaries. It raises a lane's valid in the same cycle that the lane carries the agreed sync word. From that moment each lane runs its own reference generator. The generator predicts every later byte, and the block compares the prediction with the byte that arrives.

The outputs are a registered match flag per lane and a global flag that is high only when every lane matches. Any mismatch sets a sticky error flag. It also advances an error total that saturates at 99. The total is kept as two BCD digits, and each digit is encoded for a seven-segment display. A synchronous clear input zeroes the total and drops the flag.

Top module: `prbs_lane_monitor`

## Requirements
- R1: After reset, every lane match, the global match, the error flag and the BCD total are 0, and both display digits show the pattern for zero.
- R2: A lane's valid rising (high now, low in the previous cycle) marks the sync word. That byte is not compared, and the lane's match is 0 in the following cycle. The first compared byte is the word after the sync word.
- R3: The reference stream follows b[n] = b[n-6] XOR b[n-7] (polynomial x^7+x^6+1). Eight bits are consumed per clock, and the earliest bit sits in data bit 7.
- R4: A lane's match is registered. It is 1 in the cycle after a byte only if that lane's valid was high in that cycle and the one before, and the byte equalled the predicted word.
- R5: A lane whose valid is low reads as not matching and never counts as an error, whatever its data.
- R6: The global match is 1 exactly when all lane match flags are 1.
- R7: A compared byte that differs from the prediction sets the error flag one cycle later. The flag stays set until clear.
- R8: The total rises by exactly one in each cycle that has at least one mismatching lane, however many lanes mismatch.
- R9: The total saturates at 99 and holds there under further errors.
- R10: Clear zeroes the total and the flag on the next edge, and it takes priority over an error in the same cycle.
- R11: A lane's reference keeps advancing through a mismatch, so one corrupted byte costs exactly one error and the lane matches again on the next good byte.
- R12: The total is shown as two BCD digits (tens in bits 7:4 of `err_bcd`, ones in bits 3:0). Each digit is encoded active-high with bit 0 = segment a up to bit 6 = segment g. The codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F.
- R13: Each lane's reference is started only by its own valid rising, so a lane can restart while the others keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of total and error flag |
| lane_data | input | NUM_LANES*LANE_W | Aligned bytes; lane i at bits [i*LANE_W +: LANE_W] |
| lane_valid | input | NUM_LANES | Per-lane aligned-data valid |
| lane_match | output | NUM_LANES | Registered per-lane match |
| all_match | output | 1 | All lanes match |
| err_flag | output | 1 | Sticky error indication |
| err_bcd | output | 8 | Error total as two BCD digits |
| seg_tens | output | 7 | Seven-segment pattern, tens digit |
| seg_ones | output | 7 | Seven-segment pattern, ones digit |

## Verification
The bench builds the block with four lanes of eight bits and a sync word of 8'h3C. With fewer lanes, a single test can hold every lane valid, drop and restart one lane, and corrupt one, some or all lanes in one cycle. With the lane count low, a run of more than a hundred single-lane errors fits easily. That run reaches saturation and shows every display digit on the way.

// File: rtl/prbs_mon_pkg.sv
// Shared definitions for the PRBS loopback checker.
// Assumes the reference stream uses the recurrence b[n] = b[n-6] ^ b[n-7].
package prbs_mon_pkg;
    localparam int PRBS_TAP_NEAR = 6;
    localparam int PRBS_TAP_FAR  = 7;
    localparam int DIGIT_W       = 4;
    localparam int SEG_W         = 7;

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/prbs_lane_chk.sv
// One receive lane: a reference generator plus a byte comparator.
// The generator is loaded from the sync word when valid rises. That byte is
// not compared. Every later valid byte is compared with the prediction, and
// the reference advances whether or not the byte matched.
// Assumes LANE_W >= PRBS_TAP_FAR and a non-zero sync word.
module prbs_lane_chk #(
    parameter int                LANE_W    = 8,
    parameter logic [LANE_W-1:0] SYNC_WORD = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] data_i,
    input  logic              valid_i,
    output logic              match_o,
    output logic              miss_o
);
    import prbs_mon_pkg::*;

    localparam int HIST_W = 2 * LANE_W;

    logic              valid_q;
    logic [LANE_W-1:0] ref_q;
    logic [LANE_W-1:0] ref_seed;
    logic [LANE_W-1:0] ref_next;
    logic              compare_en;

    // Next word: extend the bit history by LANE_W bits, earliest bit in the MSB.
    function automatic logic [LANE_W-1:0] prbs_advance(input logic [LANE_W-1:0] w);
        logic [HIST_W-1:0] h;
        logic [LANE_W-1:0] r;
        h = '0;
        r = '0;
        for (int j = 0; j < LANE_W; j++) h[j] = w[LANE_W-1-j];
        for (int n = LANE_W; n < HIST_W; n++)
            h[n] = h[n-PRBS_TAP_NEAR] ^ h[n-PRBS_TAP_FAR];
        for (int j = 0; j < LANE_W; j++) r[LANE_W-1-j] = h[LANE_W+j];
        return r;
    endfunction

    // Seed selection: the sync word on a valid rise, else the current prediction.
    always_comb begin
        ref_seed   = (valid_i && !valid_q) ? SYNC_WORD : ref_q;
        ref_next   = prbs_advance(ref_seed);
        compare_en = valid_i && valid_q;
        miss_o     = compare_en && (data_i != ref_q);
    end

    // Lane state: valid history, prediction and registered match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ref_q   <= '0;
            match_o <= 1'b0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) ref_q <= ref_next;
            match_o <= compare_en && (data_i == ref_q);
        end
    end

    // R4
    match_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(valid_i) && $past(valid_q)));

    // R2
    rise_not_compared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !valid_q) |=> !match_o);

    // R5
    idle_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !miss_o);
endmodule

// File: rtl/err_tally.sv
// Error bookkeeping: a sticky flag and a two-digit BCD total that saturates
// at 99. The total adds at most one per cycle. Clear takes priority over a hit.
module err_tally (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               hit,
    output logic               flag_o,
    output prbs_mon_pkg::bcd_t tens_o,
    output prbs_mon_pkg::bcd_t ones_o
);
    import prbs_mon_pkg::*;

    localparam bcd_t DIGIT_MAX = 4'd9;

    logic at_max;
    logic [6:0] total;

    // Saturation test and the binary total used by the checks.
    always_comb begin
        at_max = (tens_o == DIGIT_MAX) && (ones_o == DIGIT_MAX);
        total  = 7'(tens_o) * 7'd10 + 7'(ones_o);
    end

    // Flag and BCD counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag_o <= 1'b0;
            tens_o <= '0;
            ones_o <= '0;
        end else if (hit) begin
            flag_o <= 1'b1;
            if (!at_max) begin
                if (ones_o == DIGIT_MAX) begin
                    ones_o <= '0;
                    tens_o <= tens_o + 4'd1;
                end else begin
                    ones_o <= ones_o + 4'd1;
                end
            end
        end
    end

    // R12
    digits_decimal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tens_o <= DIGIT_MAX) && (ones_o <= DIGIT_MAX));

    // R9
    saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> at_max);

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total == 7'd0) && !flag_o);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);

    // R8
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr && !at_max) |=> (total == $past(total) + 7'd1));
endmodule

// File: rtl/seg7_enc.sv
// BCD digit to active-high seven-segment pattern, bit 0 = a .. bit 6 = g.
// Assumes a decimal digit; other codes blank the display.
module seg7_enc (
    input  prbs_mon_pkg::bcd_t digit_i,
    output prbs_mon_pkg::seg_t seg_o
);
    // Digit lookup.
    always_comb begin
        case (digit_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = 7'h00;
        endcase
    end
endmodule

// File: rtl/prbs_lane_monitor.sv
// Top level: one checker per lane, a global match, and an error tally shown
// on two seven-segment digits.
// Assumes the lane data is already byte aligned and that valid rises on the
// sync word.
module prbs_lane_monitor #(
    parameter int                NUM_LANES = 17,
    parameter int                LANE_W    = 8,
    parameter logic [LANE_W-1:0] SYNC_WORD = 8'h3C
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic [NUM_LANES*LANE_W-1:0]   lane_data,
    input  logic [NUM_LANES-1:0]          lane_valid,
    output logic [NUM_LANES-1:0]          lane_match,
    output logic                          all_match,
    output logic                          err_flag,
    output logic [7:0]                    err_bcd,
    output logic [6:0]                    seg_tens,
    output logic [6:0]                    seg_ones
);
    import prbs_mon_pkg::*;

    logic [NUM_LANES-1:0] lane_miss;
    logic                 any_miss;
    bcd_t                 tens_d;
    bcd_t                 ones_d;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        prbs_lane_chk #(
            .LANE_W    (LANE_W),
            .SYNC_WORD (SYNC_WORD)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .data_i  (lane_data[i*LANE_W +: LANE_W]),
            .valid_i (lane_valid[i]),
            .match_o (lane_match[i]),
            .miss_o  (lane_miss[i])
        );
    end

    // Reduce the lane results into the global flags.
    always_comb begin
        any_miss  = |lane_miss;
        all_match = &lane_match;
        err_bcd   = {tens_d, ones_d};
    end

    err_tally i_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .hit    (any_miss),
        .flag_o (err_flag),
        .tens_o (tens_d),
        .ones_o (ones_d)
    );

    seg7_enc i_seg_tens (.digit_i(tens_d), .seg_o(seg_tens));
    seg7_enc i_seg_ones (.digit_i(ones_d), .seg_o(seg_ones));

    // R6
    all_match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_match |-> $past(&lane_valid));

    // R5
    idle_lane_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_valid) |=> !all_match);
endmodule

// File: tb/test_prbs_lane_monitor.sv
module test_prbs_lane_monitor;
    localparam int         NL   = 4;
    localparam int         W    = 8;
    localparam logic [7:0] SYNC = 8'h3C;
    localparam logic [NL-1:0] ALL = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic [NL*W-1:0]   lane_data = '0;
    logic [NL-1:0]     lane_valid = '0;
    logic [NL-1:0]     lane_match;
    logic              all_match;
    logic              err_flag;
    logic [7:0]        err_bcd;
    logic [6:0]        seg_tens;
    logic [6:0]        seg_ones;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    logic [7:0] nxt_w [NL];

    always #4 clk = ~clk;

    prbs_lane_monitor #(.NUM_LANES(NL), .LANE_W(W), .SYNC_WORD(SYNC)) i_prbs_lane_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .lane_data(lane_data),
        .lane_valid(lane_valid), .lane_match(lane_match), .all_match(all_match),
        .err_flag(err_flag), .err_bcd(err_bcd), .seg_tens(seg_tens), .seg_ones(seg_ones)
    );

    // Serial 7-bit shift model: s[0] newest bit, new bit = bit 6 ago ^ bit 7 ago.
    function automatic logic [7:0] bnext(input logic [7:0] w);
        logic [6:0] s;
        logic [7:0] o;
        logic nb;
        s = w[6:0];
        o = '0;
        for (int k = 0; k < 8; k++) begin
            nb = s[5] ^ s[6];
            s  = {s[5:0], nb};
            o  = {o[6:0], nb};
        end
        return o;
    endfunction

    function automatic logic [6:0] seg_of(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_total(input string req);
        chk({req, " bcd"}, 32'(err_bcd), 32'({4'(exp_cnt / 10), 4'(exp_cnt % 10)}));
        chk({req, " seg_tens"}, 32'(seg_tens), 32'(seg_of(exp_cnt / 10)));
        chk({req, " seg_ones"}, 32'(seg_ones), 32'(seg_of(exp_cnt % 10)));
    endtask

    // One clock of stimulus; results are sampled 1 ns after the capturing edge.
    task automatic drive(input logic [NL-1:0] start, input logic [NL-1:0] vld,
                         input logic [NL-1:0] bad, input logic c);
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            if (start[l]) begin
                lane_data[l*W +: W] = SYNC;
                nxt_w[l] = bnext(SYNC);
                lane_valid[l] = 1'b1;
            end else if (vld[l]) begin
                lane_data[l*W +: W] = nxt_w[l] ^ (bad[l] ? 8'hFF : 8'h00);
                nxt_w[l] = bnext(nxt_w[l]);
                lane_valid[l] = 1'b1;
            end else begin
                lane_data[l*W +: W] = 8'hA7;
                lane_valid[l] = 1'b0;
            end
        end
        clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 lane_match", 32'(lane_match), 0);
        chk("R1 all_match", 32'(all_match), 0);
        chk("R1 err_flag", 32'(err_flag), 0);
        exp_cnt = 0;
        chk_total("R1 R12 zero");
    endtask

    task automatic t_lock();
        drive(ALL, ALL, '0, 1'b0);
        chk("R2 sync byte not compared", 32'(lane_match), 0);
        chk("R6 all_match low", 32'(all_match), 0);
        for (int k = 0; k < 20; k++) begin
            drive('0, ALL, '0, 1'b0);
            chk("R3 R4 stream match", 32'(lane_match), 32'(ALL));
            chk("R6 all_match", 32'(all_match), 1);
            chk("R4 no error", 32'(err_flag), 0);
        end
    endtask

    task automatic t_idle_restart();
        for (int k = 0; k < 3; k++) begin
            drive('0, 4'b1011, '0, 1'b0);
            chk("R5 idle lane no match", 32'(lane_match), 32'(4'b1011));
            chk("R6 all_match low", 32'(all_match), 0);
            chk("R5 idle lane no error", 32'(err_flag), 0);
        end
        chk_total("R5 total");
        drive(4'b0100, ALL, '0, 1'b0);
        chk("R13 restart rise", 32'(lane_match), 32'(4'b1011));
        for (int k = 0; k < 4; k++) begin
            drive('0, ALL, '0, 1'b0);
            chk("R13 restarted lane tracks", 32'(lane_match), 32'(ALL));
        end
        chk("R13 no error", 32'(err_flag), 0);
    endtask

    task automatic t_single();
        drive('0, ALL, 4'b0010, 1'b0);
        exp_cnt = 1;
        chk("R4 corrupt lane", 32'(lane_match), 32'(4'b1101));
        chk("R7 flag set", 32'(err_flag), 1);
        chk_total("R7 one error");
        for (int k = 0; k < 3; k++) begin
            drive('0, ALL, '0, 1'b0);
            chk("R11 recovers", 32'(lane_match), 32'(ALL));
            chk("R7 sticky", 32'(err_flag), 1);
            chk_total("R11 single error");
        end
    endtask

    task automatic t_multi();
        drive('0, ALL, ALL, 1'b0);
        exp_cnt = 2;
        chk_total("R8 all lanes bad");
        drive('0, ALL, 4'b0101, 1'b0);
        exp_cnt = 3;
        chk_total("R8 two lanes bad");
        chk("R4 partial", 32'(lane_match), 32'(4'b1010));
    endtask

    task automatic t_clear();
        drive('0, ALL, 4'b0001, 1'b1);
        exp_cnt = 0;
        chk_total("R10 clear wins");
        chk("R10 flag cleared", 32'(err_flag), 0);
        drive('0, ALL, '0, 1'b0);
        chk("R10 flag stays clear", 32'(err_flag), 0);
        chk_total("R10 after clear");
    endtask

    task automatic t_sat();
        for (int k = 1; k <= 105; k++) begin
            drive('0, ALL, 4'b0001, 1'b0);
            exp_cnt = (k > 99) ? 99 : k;
            chk_total("R9 R12 count");
        end
        drive('0, ALL, '0, 1'b0);
        chk_total("R9 held at max");
        chk("R11 lane 0 back", 32'(lane_match), 32'(ALL));
        drive('0, ALL, '0, 1'b1);
        exp_cnt = 0;
        chk_total("R10 clear from max");
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) nxt_w[l] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_lock();
        t_idle_restart();
        t_single();
        t_multi();
        t_clear();
        t_sat();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule